// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block holds a small bank of request generators that let an external event start a DMA transfer with no peripheral behind it. Each generator picks one line from a shared set of trigger inputs, watches it for a programmed edge, and answers each detected edge with a programmed number of DMA requests. Those requests feed a request router as extra sources. The trigger set is generic, so it can include events that the router loops back.

Requests leave on a valid/ready style handshake: `req_o` acts as valid and `ack_i` acts as ready. The generator raises a request and holds it until the DMA accepts it. A request is accepted on a rising clock edge where both `req_o` and `ack_i` are high. After each acceptance `req_o` falls for exactly one cycle before the next request of the same burst. While `req_o` is low, `ack_i` has no effect. A trigger edge that arrives while a burst is still running is thrown away and sets a sticky overrun flag. Any set flag drives the shared interrupt line.

Top module: `trig_req_gen`

## Requirements
- R1: After reset, every `req_o`, every `ovr_o` and `irq_o` are low.
- R2: Each generator has a 2-bit edge mode. 0 never triggers, 1 triggers on a rising edge, 2 on a falling edge and 3 on either edge of the selected line. A detected edge starts a burst with its first request visible in the cycle after the clock edge at which the new line level is sampled.
- R3: Field `sel_i[g*3 +: 3]` selects which bit of `trig_i` generator g watches. Edges on other lines have no effect on it.
- R4: Field `cnt_i[g*5 +: 5]` holds N-1, and one trigger edge produces exactly N requests (1 to 32).
- R5: A raised request stays high until accepted. `ack_i` has no effect while the request is low.
- R6: After each acceptance the request is low in the following cycle. The next request of the burst rises one cycle later.
- R7: A trigger edge detected while a burst is in progress, including the cycle of its final acceptance, sets that generator's overrun flag. The edge is discarded, so the running burst keeps its length and no further burst follows.
- R8: An overrun flag stays set until a cycle with `ovr_clr_i[g]` high clears it. A new overrun in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when at least one overrun flag is set.
- R10: While `en_i[g]` is low, edges on the selected line are ignored. Dropping `en_i[g]` during a burst lowers the request in the next cycle and discards the rest of the burst.
- R11: Generators are independent: activity on one never raises another's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | NTRIG | Synchronous trigger lines |
| en_i | input | NGEN | Per-generator enable |
| edge_i | input | 2*NGEN | Per-generator edge mode, 2 bits each |
| sel_i | input | SELW*NGEN | Per-generator trigger line index |
| cnt_i | input | CNTW*NGEN | Per-generator request count minus one |
| ack_i | input | NGEN | Per-generator request acceptance (ready) |
| ovr_clr_i | input | NGEN | Per-generator overrun clear pulse |
| req_o | output | NGEN | Per-generator DMA request (valid) |
| ovr_o | output | NGEN | Per-generator sticky overrun flag |
| irq_o | output | 1 | OR of all overrun flags |

## Verification
The bench targets the following failure modes:
- **Wrong edge or wrong line.** Bursts are run with each edge mode against both polarities of the selected line, and with edges driven on a line the generator is not watching. A polarity or mux slip shows up as a burst that should not appear, or as a missing one.
- **Off-by-one count.** The full 32-request count is tested, because a design that miscounts N-1 produces one request too many or too few.
- **Overrun handling.** A second edge is sent mid-burst. A design that queues or restarts on that edge would lengthen the burst. A design without a sticky flag would lose the flag before software clears it.
- **Disable paths.** One test aborts a burst part-way. Another sends a trigger while the generator is disabled. A design that keeps counting, or that latches the edge, then raises a request after being re-enabled.

// File: rtl/trig_req_pkg.sv
package trig_req_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_t;

endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det
  import trig_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  edge_mode_t mode_i,
  output logic       hit_o
);

  logic prev_q;

  // previous level tracks the line regardless of enable, so enabling
  // while the line is already high never fakes an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_i;
  end

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = line_i & ~prev_q;
      EDGE_FALL: hit_o = ~line_i & prev_q;
      EDGE_BOTH: hit_o = line_i ^ prev_q;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/req_burst_gen.sv
module req_burst_gen #(
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            hit_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            ack_i,
  input  logic            ovr_clr_i,
  output logic            req_o,
  output logic            ovr_o
);

  logic            busy_q;
  logic            req_q;
  logic [CNTW-1:0] left_q;
  logic            ovr_q;
  logic            clash;

  assign clash = en_i & busy_q & hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      left_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      left_q <= '0;
    end else if (busy_q) begin
      if (req_q && ack_i) begin
        req_q <= 1'b0;
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end else if (!req_q) begin
        req_q <= 1'b1;
      end
    end else if (hit_i) begin
      busy_q <= 1'b1;
      req_q  <= 1'b1;
      left_q <= cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (clash)     ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign req_o = req_q;
  assign ovr_o = ovr_q;

  // R5: an unaccepted request persists while enabled
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i && en_i) |=> (req_q || !en_i));

  // R6: acceptance is followed by a low cycle
  p_req_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack_i) |=> !req_q);

  // R7: a trigger edge during a burst marks overrun
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> ovr_q);

  // R8: flag only leaves on a clear without a fresh clash
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr_i) |=> ovr_q);

  // R10: disabled generator drops its request
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !req_q);

  // R2: an accepted edge on an idle generator raises a request
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !busy_q && hit_i) |=> req_q);

endmodule

// File: rtl/trig_req_gen.sv
module trig_req_gen
  import trig_req_pkg::*;
#(
  parameter int NGEN  = 4,
  parameter int NTRIG = 8,
  parameter int CNTW  = 5,
  localparam int SELW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTRIG-1:0]     trig_i,
  input  logic [NGEN-1:0]      en_i,
  input  logic [2*NGEN-1:0]    edge_i,
  input  logic [SELW*NGEN-1:0] sel_i,
  input  logic [CNTW*NGEN-1:0] cnt_i,
  input  logic [NGEN-1:0]      ack_i,
  input  logic [NGEN-1:0]      ovr_clr_i,
  output logic [NGEN-1:0]      req_o,
  output logic [NGEN-1:0]      ovr_o,
  output logic                 irq_o
);

  logic [NGEN-1:0] line;
  logic [NGEN-1:0] hit;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    logic [SELW-1:0] sel;
    assign sel = sel_i[g*SELW +: SELW];

    always_comb begin
      line[g] = 1'b0;
      for (int t = 0; t < NTRIG; t++) begin
        if (sel == SELW'(t)) line[g] = trig_i[t];
      end
    end

    trig_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line[g]),
      .mode_i (edge_mode_t'(edge_i[g*2 +: 2])),
      .hit_o  (hit[g])
    );

    req_burst_gen #(.CNTW(CNTW)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i[g]),
      .hit_i     (hit[g]),
      .cnt_i     (cnt_i[g*CNTW +: CNTW]),
      .ack_i     (ack_i[g]),
      .ovr_clr_i (ovr_clr_i[g]),
      .req_o     (req_o[g]),
      .ovr_o     (ovr_o[g])
    );
  end

  assign irq_o = |ovr_o;

  // R9: a raised interrupt always has a set flag behind it
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(ovr_o) > 0));

endmodule

// File: tb/sim_trig_req_gen.sv
module sim_trig_req_gen;

  localparam int CLK_P = 10;
  localparam int NGEN  = 4;
  localparam int NTRIG = 8;
  localparam int WD    = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NTRIG-1:0]  trig = '0;
  logic [NGEN-1:0]   en = '0;
  logic [2*NGEN-1:0] edg = '0;
  logic [3*NGEN-1:0] sel = '0;
  logic [5*NGEN-1:0] cnt = '0;
  logic [NGEN-1:0]   ack = '0;
  logic [NGEN-1:0]   clr = '0;
  logic [NGEN-1:0]   req;
  logic [NGEN-1:0]   ovr;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .en_i(en), .edge_i(edg),
    .sel_i(sel), .cnt_i(cnt), .ack_i(ack), .ovr_clr_i(clr),
    .req_o(req), .ovr_o(ovr), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0] g;
    logic [2:0] s;
    logic [2:0] tl;
    logic [1:0] md;
    logic       lv0;
    logic       lv1;
    logic [4:0] c;
    logic [1:0] dly;
    logic [5:0] exp;
  } vec_t;

  // gen, sel, toggled line, mode, level before, level after, count-1, ack delay, expected
  localparam vec_t VECS [10] = '{
    '{2'd0, 3'd2, 3'd2, 2'd1, 1'b0, 1'b1, 5'd0,  2'd0, 6'd1},
    '{2'd1, 3'd5, 3'd5, 2'd2, 1'b1, 1'b0, 5'd3,  2'd1, 6'd4},
    '{2'd2, 3'd7, 3'd7, 2'd3, 1'b0, 1'b1, 5'd1,  2'd2, 6'd2},
    '{2'd3, 3'd0, 3'd0, 2'd3, 1'b1, 1'b0, 5'd2,  2'd0, 6'd3},
    '{2'd0, 3'd2, 3'd2, 2'd1, 1'b1, 1'b0, 5'd4,  2'd0, 6'd0},
    '{2'd1, 3'd5, 3'd5, 2'd2, 1'b0, 1'b1, 5'd4,  2'd0, 6'd0},
    '{2'd2, 3'd3, 3'd3, 2'd0, 1'b0, 1'b1, 5'd2,  2'd0, 6'd0},
    '{2'd3, 3'd1, 3'd1, 2'd1, 1'b0, 1'b1, 5'd31, 2'd0, 6'd32},
    '{2'd0, 3'd6, 3'd4, 2'd1, 1'b0, 1'b1, 5'd3,  2'd0, 6'd0},
    '{2'd1, 3'd6, 3'd6, 2'd1, 1'b0, 1'b1, 5'd15, 2'd3, 6'd16}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, expv, $time);
    end
  endtask

  task automatic cfg(input int g, input int s, input int md, input int c);
    sel[g*3 +: 3] = 3'(s);
    edg[g*2 +: 2] = 2'(md);
    cnt[g*5 +: 5] = 5'(c);
  endtask

  // acknowledge every request of generator g after dly cycles and count them
  task automatic drain(input int g, input int dly, output int n);
    int idle = 0;
    n = 0;
    while (idle < 6) begin
      @(negedge clk);
      chk((req & ~(NGEN'(1) << g)) == '0, "R11", int'(req), 0);
      if (req[g]) begin
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk(req[g] == 1'b1, "R5", int'(req[g]), 1);
        end
        ack[g] = 1'b1;
        @(negedge clk);
        ack[g] = 1'b0;
        n++;
        chk(req[g] == 1'b0, "R6", int'(req[g]), 0);
        idle = 0;
      end else begin
        idle++;
      end
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req == '0, "R1", int'(req), 0);
    chk(ovr == '0, "R1", int'(ovr), 0);
    chk(irq == 1'b0, "R1", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 edge modes, R3 line select, R4 counts
    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      en = '0;
      trig = '0;
      cfg(v.g, v.s, v.md, v.c);
      trig[v.tl] = v.lv0;
      repeat (2) @(negedge clk);
      en[v.g] = 1'b1;
      @(negedge clk);
      trig[v.tl] = v.lv1;
      drain(v.g, v.dly, n);
      chk(n == v.exp, "R2/R3/R4 count", n, v.exp);
      chk(ovr == '0, "R7", int'(ovr), 0);
      en = '0;
      trig = '0;
      repeat (2) @(negedge clk);
    end

    // R7 overrun: second edge mid-burst is discarded and flagged
    cfg(0, 0, 1, 3);
    en[0] = 1'b1;
    @(negedge clk);
    trig[0] = 1'b1;
    repeat (2) @(negedge clk);
    trig[0] = 1'b0;
    @(negedge clk);
    chk(ovr[0] == 1'b0, "R7", int'(ovr[0]), 0);
    trig[0] = 1'b1;
    @(negedge clk);
    chk(ovr[0] == 1'b1, "R7", int'(ovr[0]), 1);
    chk(irq == 1'b1, "R9", int'(irq), 1);
    drain(0, 0, n);
    chk(n == 4, "R7 burst length", n, 4);
    chk(ovr[0] == 1'b1, "R8 sticky", int'(ovr[0]), 1);
    clr[0] = 1'b1;
    @(negedge clk);
    clr[0] = 1'b0;
    chk(ovr[0] == 1'b0, "R8 clear", int'(ovr[0]), 0);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    trig[0] = 1'b0;
    en = '0;
    repeat (2) @(negedge clk);

    // R10 trigger while disabled is ignored
    cfg(2, 4, 1, 0);
    @(negedge clk);
    trig[4] = 1'b1;
    repeat (2) @(negedge clk);
    en[2] = 1'b1;
    repeat (5) @(negedge clk);
    chk(req[2] == 1'b0, "R10 disabled trigger", int'(req[2]), 0);
    en = '0;
    trig = '0;
    repeat (2) @(negedge clk);

    // R10 abort mid-burst
    cfg(3, 5, 1, 9);
    en[3] = 1'b1;
    @(negedge clk);
    trig[5] = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(req[3] == 1'b1, "R5", int'(req[3]), 1);
      ack[3] = 1'b1;
      @(negedge clk);
      ack[3] = 1'b0;
      @(negedge clk);
    end
    chk(req[3] == 1'b1, "R6 next request", int'(req[3]), 1);
    en[3] = 1'b0;
    @(negedge clk);
    chk(req[3] == 1'b0, "R10 abort", int'(req[3]), 0);
    en[3] = 1'b1;
    repeat (6) @(negedge clk);
    chk(req[3] == 1'b0, "R10 remainder discarded", int'(req[3]), 0);
    chk(ovr[3] == 1'b0, "R7", int'(ovr[3]), 0);
    en = '0;
    trig = '0;
    repeat (2) @(negedge clk);

    // R5 ack while request low has no effect
    cfg(1, 2, 1, 1);
    en[1] = 1'b1;
    ack[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk(req[1] == 1'b0, "R5 idle ack", int'(req[1]), 0);
    ack[1] = 1'b0;
    trig[2] = 1'b1;
    drain(1, 1, n);
    chk(n == 2, "R4 after idle ack", n, 2);
    en = '0;
    trig = '0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule